// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

The engine turns interrupt input lines into message-signalled interrupt writes. Every pin has a 64-bit redirection entry. The entry holds a vector, a delivery mode, a destination and its mode, a trigger type, a mask and a remote-request flag. When a pin has a request pending and its entry is unmasked, the engine builds a 32-bit address and a 32-bit data word from the entry. It presents them on a valid/ready message port, one message at a time.

Edge pins latch a rising input into a pending register. Level pins have a pending bit that follows the input. A level pin also sets its remote-request flag when it is delivered. It is not delivered again while that flag stays set. The flag is cleared only by rewriting the entry as edge-triggered. The normal way to do this is with the entry masked: rewrite it as masked edge, then as level again. A simple write port programs the entries and a separate index reads them back. Input 0 is steered onto pin 2.

Pins are scanned in ascending order. A scan starts again from pin 0 whenever an input changes the pending register or an entry is written. While the message port is stalled, the scan waits.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset, no message is valid and every entry reads back as 64'h0000_0000_0001_0000 (masked, all other fields zero).
- R2: The entry fields sit at these bit positions: vector [7:0], delivery mode [10:8], destination mode [11], remote flag [14], trigger [15] (1 = level), mask [16], destination [63:48]. Every other bit reads as zero. A write or read at an index at or above the pin count has no effect and reads zero.
- R3: The remote flag cannot be written through the write port. Writing an entry with trigger 0 (edge) clears the flag.
- R4: A message has address 32'hFEE0_0000 | destination<<4 | destination mode<<2. Its data is vector | delivery mode<<8 | trigger<<15.
- R5: Each rising edge on an unmasked edge pin produces exactly one message.
- R6: A rising edge on a masked edge pin is discarded. Unmasking the pin later produces no message.
- R7: The pending bit of a level pin follows its input. While the pin is masked, the pending bit is kept and no message is sent. Unmasking it then produces one message.
- R8: Delivering a level pin sets its remote flag. While the flag is set, the pin produces no further message, even if its input goes low and then high again.
- R9: Input 0 and input 2 both drive pin 2. Pin 0 has no source.
- R10: When several pins are pending at the same time, their messages go out in ascending pin order.
- R11: While valid is high and ready is low, the valid, address and data outputs hold steady, and no message is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_PINS | Interrupt input lines |
| cfg_wr_i | input | 1 | Entry write strobe |
| cfg_idx_i | input | IDX_W | Index of the entry to write |
| cfg_wdata_i | input | 64 | Entry write data |
| cfg_rd_idx_i | input | IDX_W | Index of the entry to read |
| cfg_rdata_o | output | 64 | Entry read data (combinational) |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The bench targets the following corner cases, each tied to the faulty behaviour it would expose:

- **Masked edge request dropped.** An edge request is pulsed while its pin is masked, and the pin is then unmasked. A design that latched the request anyway would emit a stray message.
- **Masked level request kept.** A level pin is held high while masked, and then unmasked. A design that dropped the pending bit would never deliver.
- **Remote-flag gating.** A level input is toggled after its first delivery. A design that ignored the flag would send repeats.
- **Flag clear by rewrite.** A masked edge rewrite followed by a level rewrite must clear the flag and trigger a new delivery.
- **Pin 2 routing.** Input 0 must reach pin 2 and not pin 0.
- **Ordering under back-pressure.** Two pins fire together while ready is low. A wrong order, a changing payload or a lost second message is reported.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

  typedef struct packed {
    logic [15:0] dest;
    logic        masked;
    logic        level;
    logic        remote;
    logic        dst_logical;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } rte_t;

  localparam rte_t RTE_RESET = '{masked: 1'b1, default: '0};

  function automatic rte_t rte_unpack(input logic [63:0] w);
    rte_t e;
    e.dest        = w[63:48];
    e.masked      = w[16];
    e.level       = w[15];
    e.remote      = w[14];
    e.dst_logical = w[11];
    e.dlv         = w[10:8];
    e.vec         = w[7:0];
    return e;
  endfunction

  function automatic logic [63:0] rte_pack(input rte_t e);
    logic [63:0] w;
    w          = '0;
    w[63:48]   = e.dest;
    w[16]      = e.masked;
    w[15]      = e.level;
    w[14]      = e.remote;
    w[11]      = e.dst_logical;
    w[10:8]    = e.dlv;
    w[7:0]     = e.vec;
    return w;
  endfunction

  function automatic logic [31:0] msg_addr(input rte_t e);
    return MSG_BASE | (32'(e.dest) << 4) | (32'(e.dst_logical) << 2);
  endfunction

  function automatic logic [31:0] msg_data(input rte_t e);
    return 32'(e.vec) | (32'(e.dlv) << 8) | (32'(e.level) << 15);
  endfunction

endpackage

// File: rtl/irq_redir_input_map.sv
module irq_redir_input_map #(
  parameter int NUM_PINS = 24
) (
  input  logic [NUM_PINS-1:0] irq_i,
  output logic [NUM_PINS-1:0] pin_lvl_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == 0) begin : g_none
      assign pin_lvl_o[p] = 1'b0;
    end else if (p == 2) begin : g_merge
      assign pin_lvl_o[p] = irq_i[2] | irq_i[0];
    end else begin : g_direct
      assign pin_lvl_o[p] = irq_i[p];
    end
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [63:0]         wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [63:0]         rd_data_o,
  input  logic [NUM_PINS-1:0] set_remote_i,
  output rte_t                ent_o [NUM_PINS],
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic                wr_hit_o
);
  rte_t ent_q [NUM_PINS];
  rte_t wr_ent;

  assign wr_ent   = rte_unpack(wr_data_i);
  assign wr_hit_o = wr_i && ({1'b0, wr_idx_i} < (IDX_W+1)'(NUM_PINS));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[p] <= RTE_RESET;
      end else if (wr_hit_o && wr_idx_i == IDX_W'(p)) begin
        ent_q[p]        <= wr_ent;
        // remote flag survives writes, dropped when the pin becomes edge
        ent_q[p].remote <= wr_ent.level & (ent_q[p].remote | set_remote_i[p]);
      end else if (set_remote_i[p]) begin
        ent_q[p].remote <= 1'b1;
      end
    end
    assign ent_o[p]   = ent_q[p];
    assign level_o[p] = ent_q[p].level;
    assign mask_o[p]  = ent_q[p].masked;
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx_i == IDX_W'(p)) rd_data_o = rte_pack(ent_q[p]);
    end
  end
endmodule

// File: rtl/irq_redir_pending.sv
module irq_redir_pending #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_lvl_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o,
  output logic                change_o
);
  logic [NUM_PINS-1:0] pend_q, prev_q, rise, ext, pend_d;

  assign rise = pin_lvl_i & ~prev_q;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (level_i[p]) begin
        ext[p]    = pin_lvl_i[p];
        pend_d[p] = pin_lvl_i[p];
      end else begin
        ext[p]    = pend_q[p] | (rise[p] & ~mask_i[p]);
        // a fresh edge wins over a same-cycle service clear
        pend_d[p] = (pend_q[p] & ~clr_i[p]) | (rise[p] & ~mask_i[p]);
      end
    end
  end

  // only input-driven changes restart the scan
  assign change_o = |(ext ^ pend_q);
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= pin_lvl_i;
    end
  end
endmodule

// File: rtl/irq_redir_scan.sv
module irq_redir_scan
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic [NUM_PINS-1:0] pend_i,
  input  rte_t                ent_i [NUM_PINS],
  output logic [NUM_PINS-1:0] clr_o,
  output logic [NUM_PINS-1:0] set_remote_o,
  output logic [IDX_W-1:0]    ptr_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             busy_q, vld_q;
  logic [31:0]      addr_q, data_q;
  logic             slot_free, eval, serve, fire;
  rte_t             cur;

  assign cur       = ent_i[ptr_q];
  assign slot_free = !vld_q || msg_ready_i;
  assign eval      = busy_q && slot_free;
  assign serve     = eval && pend_i[ptr_q] && !cur.masked;
  assign fire      = serve && (!cur.level || !cur.remote);

  always_comb begin
    clr_o        = '0;
    set_remote_o = '0;
    if (serve && !cur.level) clr_o[ptr_q]        = 1'b1;
    if (serve &&  cur.level) set_remote_o[ptr_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else if (restart_i) begin
      ptr_q  <= '0;
      busy_q <= 1'b1;
    end else if (eval) begin
      if (ptr_q == LAST) busy_q <= 1'b0;
      else               ptr_q  <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      vld_q  <= 1'b1;
      addr_q <= msg_addr(cur);
      data_q <= msg_data(cur);
    end else if (msg_ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign ptr_o       = ptr_q;
  assign msg_valid_o = vld_q;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                cfg_wr_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic [63:0]         cfg_wdata_i,
  input  logic [IDX_W-1:0]    cfg_rd_idx_i,
  output logic [63:0]         cfg_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [31:0]         msg_addr_o,
  output logic [31:0]         msg_data_o
);
  logic [NUM_PINS-1:0] pin_lvl, level_vec, mask_vec, pend, clr, set_remote;
  logic                wr_hit, pend_change, restart;
  logic [IDX_W-1:0]    scan_ptr;
  rte_t                ent [NUM_PINS];

  irq_redir_input_map #(.NUM_PINS(NUM_PINS)) u_map (
    .irq_i     (irq_i),
    .pin_lvl_o (pin_lvl)
  );

  irq_redir_table #(.NUM_PINS(NUM_PINS)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cfg_wr_i),
    .wr_idx_i     (cfg_idx_i),
    .wr_data_i    (cfg_wdata_i),
    .rd_idx_i     (cfg_rd_idx_i),
    .rd_data_o    (cfg_rdata_o),
    .set_remote_i (set_remote),
    .ent_o        (ent),
    .level_o      (level_vec),
    .mask_o       (mask_vec),
    .wr_hit_o     (wr_hit)
  );

  irq_redir_pending #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_lvl_i (pin_lvl),
    .level_i   (level_vec),
    .mask_i    (mask_vec),
    .clr_i     (clr),
    .pend_o    (pend),
    .change_o  (pend_change)
  );

  assign restart = pend_change | wr_hit;

  irq_redir_scan #(.NUM_PINS(NUM_PINS)) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (restart),
    .pend_i       (pend),
    .ent_i        (ent),
    .clr_o        (clr),
    .set_remote_o (set_remote),
    .ptr_o        (scan_ptr),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_addr_o   (msg_addr_o),
    .msg_data_o   (msg_data_o)
  );
endmodule

// File: rtl/irq_redirect_engine_chk.sv
module irq_redirect_engine_chk #(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic [31:0]      msg_addr_o,
  input logic [31:0]      msg_data_o,
  input logic [63:0]      cfg_rdata_o,
  input logic [IDX_W-1:0] scan_ptr
);
  a_r11_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=>
      msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

  a_r4_addr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_addr_o[31:20] == 12'hFEE && !msg_addr_o[3] && msg_addr_o[1:0] == 2'b00);

  a_r4_data_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:16] == 16'h0 && msg_data_o[14:11] == 4'h0);

  a_r3_edge_no_remote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[15] |-> !cfg_rdata_o[14]);

  a_r10_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, scan_ptr} < (IDX_W+1)'(NUM_PINS));

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !msg_valid_o);
endmodule

bind irq_redirect_engine irq_redirect_engine_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_addr_o  (msg_addr_o),
  .msg_data_o  (msg_data_o),
  .cfg_rdata_o (cfg_rdata_o),
  .scan_ptr    (scan_ptr)
);

// File: tb/irq_redirect_engine_tb_top.sv
module irq_redirect_engine_tb_top;
  localparam int NP    = 24;
  localparam int IDX_W = $clog2(NP);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    irq = '0;
  logic             cfg_wr = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [63:0]      cfg_wdata = '0;
  logic [IDX_W-1:0] cfg_rd_idx = '0;
  logic [63:0]      cfg_rdata;
  logic             msg_valid;
  logic             msg_ready = 1'b1;
  logic [31:0]      msg_addr, msg_data;

  int checks = 0, failures = 0, n_msg = 0;
  bit done = 1'b0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always #5 clk = ~clk;

  irq_redirect_engine #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_rd_idx_i(cfg_rd_idx), .cfg_rdata_o(cfg_rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      log_addr[n_msg % 64] = msg_addr;
      log_data[n_msg % 64] = msg_data;
      n_msg++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
                                     input logic dmode, input logic lvl,
                                     input logic msk, input logic [15:0] dest);
    return (64'(dest) << 48) | (64'(msk) << 16) | (64'(lvl) << 15) |
           (64'(dmode) << 11) | (64'(dlv) << 8) | 64'(vec);
  endfunction

  function automatic logic [31:0] ea(input logic [15:0] dest, input logic dmode);
    return 32'hFEE0_0000 | (32'(dest) << 4) | (32'(dmode) << 2);
  endfunction

  task automatic wr(input int idx, input logic [63:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_idx = IDX_W'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] d);
    cfg_rd_idx = IDX_W'(idx);
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input int line);
    @(posedge clk); #1 irq[line] = 1'b1;
    @(posedge clk); #1 irq[line] = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 valid after reset", 64'(msg_valid), 64'd0);
    rd(5, d);  chk("R1 entry 5 reset", d, 64'h1_0000);
    rd(23, d); chk("R1 entry 23 reset", d, 64'h1_0000);
  endtask

  task automatic t_layout();
    logic [63:0] d;
    wr(20, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(20, d);
    chk("R2 R3 field layout, remote not writable", d, 64'hFFFF_0000_0001_8FFF);
    wr(30, mk(8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 16'h1));
    rd(30, d); chk("R2 out-of-range read", d, 64'd0);
    rd(20, d); chk("R2 out-of-range write harmless", d, 64'hFFFF_0000_0001_8FFF);
    settle();
    chk("R2 no message from out-of-range write", 64'(n_msg), 64'd0);
  endtask

  task automatic t_edge();
    int base;
    wr(5, mk(8'h41, 3'd0, 1'b1, 1'b0, 1'b0, 16'h0203));
    settle();
    base = n_msg;
    pulse(5); settle();
    chk("R5 one message per edge", 64'(n_msg - base), 64'd1);
    chk("R4 edge addr", 64'(log_addr[base % 64]), 64'(ea(16'h0203, 1'b1)));
    chk("R4 edge data", 64'(log_data[base % 64]), 64'h41);
    pulse(5); settle();
    chk("R5 second edge", 64'(n_msg - base), 64'd2);
  endtask

  task automatic t_masked_edge();
    int base;
    base = n_msg;
    wr(6, mk(8'h46, 3'd0, 1'b0, 1'b0, 1'b1, 16'h6));
    pulse(6); settle();
    wr(6, mk(8'h46, 3'd0, 1'b0, 1'b0, 1'b0, 16'h6));
    settle();
    chk("R6 masked edge discarded", 64'(n_msg - base), 64'd0);
  endtask

  task automatic t_masked_level();
    int base;
    base = n_msg;
    wr(7, mk(8'h57, 3'd1, 1'b0, 1'b1, 1'b1, 16'h0007));
    @(posedge clk); #1 irq[7] = 1'b1;
    settle();
    chk("R7 masked level silent", 64'(n_msg - base), 64'd0);
    wr(7, mk(8'h57, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0007));
    settle();
    chk("R7 unmask delivers", 64'(n_msg - base), 64'd1);
    chk("R4 level addr", 64'(log_addr[base % 64]), 64'(ea(16'h0007, 1'b0)));
    chk("R4 level data", 64'(log_data[base % 64]), 64'h8157);
    irq[7] = 1'b0;
  endtask

  task automatic t_remote();
    int base;
    logic [63:0] d;
    base = n_msg;
    wr(8, mk(8'h58, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0011));
    @(posedge clk); #1 irq[8] = 1'b1;
    settle();
    chk("R8 first level delivery", 64'(n_msg - base), 64'd1);
    rd(8, d); chk("R8 remote flag set", 64'(d[14]), 64'd1);
    @(posedge clk); #1 irq[8] = 1'b0;
    settle();
    @(posedge clk); #1 irq[8] = 1'b1;
    settle();
    chk("R8 no redelivery while remote set", 64'(n_msg - base), 64'd1);
    wr(8, mk(8'h58, 3'd0, 1'b1, 1'b0, 1'b1, 16'h0011));
    rd(8, d); chk("R3 edge rewrite clears remote", 64'(d[14]), 64'd0);
    settle();
    chk("R8 masked edge rewrite silent", 64'(n_msg - base), 64'd1);
    wr(8, mk(8'h58, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0011));
    settle();
    chk("R8 redelivery after clear", 64'(n_msg - base), 64'd2);
    chk("R4 level data pin 8", 64'(log_data[(base + 1) % 64]), 64'h8058);
    irq[8] = 1'b0;
  endtask

  task automatic t_pin2();
    int base;
    wr(0, mk(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    wr(2, mk(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0));
    settle();
    base = n_msg;
    pulse(0); settle();
    chk("R9 input 0 gives one message", 64'(n_msg - base), 64'd1);
    chk("R9 input 0 lands on pin 2", 64'(log_data[base % 64]), 64'h22);
    pulse(2); settle();
    chk("R9 input 2 also pin 2", 64'(log_data[(base + 1) % 64]), 64'h22);
  endtask

  task automatic t_order_stall();
    int base;
    logic [31:0] a0;
    wr(10, mk(8'h3A, 3'd2, 1'b0, 1'b0, 1'b0, 16'h000A));
    wr(3,  mk(8'h33, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003));
    settle();
    base = n_msg;
    msg_ready = 1'b0;
    @(posedge clk); #1 irq[10] = 1'b1; irq[3] = 1'b1;
    @(posedge clk); #1 irq[10] = 1'b0; irq[3] = 1'b0;
    settle();
    chk("R11 valid held under stall", 64'(msg_valid), 64'd1);
    chk("R10 lowest pin first", 64'(msg_data), 64'h33);
    a0 = msg_addr;
    repeat (7) @(posedge clk); #1;
    chk("R11 addr stable", 64'(msg_addr), 64'(a0));
    chk("R11 data stable", 64'(msg_data), 64'h33);
    msg_ready = 1'b1;
    settle();
    chk("R11 both delivered", 64'(n_msg - base), 64'd2);
    chk("R10 order first", 64'(log_data[base % 64]), 64'h33);
    chk("R10 order second", 64'(log_data[(base + 1) % 64]), 64'h23A);
    chk("R4 pin 10 addr", 64'(log_addr[(base + 1) % 64]), 64'(ea(16'h000A, 1'b0)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_layout();
    t_edge();
    t_masked_edge();
    t_masked_level();
    t_remote();
    t_pin2();
    t_order_stall();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule